// File: doc/BRIEF.md
# Multi-Mode Acquisition Trigger Controller

This block decides when a multi-channel sampling front end takes samples. One of four trigger sources is selected: a software strobe, an external digital input, an event from an analog comparator, or a line of a synchronization bus shared by several boards. Each trigger event then starts a capture of N sample strobes. The capture runs in one of three modes:

- post-trigger: one block of N samples, then stop;
- delayed trigger: the block starts after a programmed number of sample ticks;
- re-trigger: the controller returns to the armed state after each block.

All counting is done in units of `sample_tick`. This is a one-cycle strobe in the system clock domain that marks each period of the sample clock.

In bus-master role, a local trigger does not start the capture at once. The controller first issues a one-tick sync-start pulse, which aligns the converters on every board. It then drives the shared trigger line and starts its own capture. In non-master role with the bus source selected, the board behaves as a slave and captures on the bus line. The controller leaves idle only after an arm strobe and goes back to idle on a disarm strobe. A sticky flag records trigger events that arrived while a capture was in progress.

Top module: `acq_trig_ctrl`

## Requirements
- R1: `src_sel` picks the trigger source: 0 software strobe, 1 external input, 2 analog event, 3 bus line. Events on the other sources have no effect. With `bus_master` high, code 3 yields no trigger.
- R2: A trigger is the rising edge of the selected input. The external and bus inputs each pass through a two-flop synchronizer first. An input held high produces only one event.
- R3: With `mode_sel`=0 (post), a trigger in the armed state produces exactly `num_samples` `sample_en` pulses. The first pulse comes on the first `sample_tick` after the trigger, and the controller then returns to idle.
- R4: With `mode_sel`=1 (delay), the first sample comes `delay_ticks` ticks later than it would in post mode. A `delay_ticks` of 0 gives the same timing as post mode.
- R5: With `mode_sel`=2 (re-trigger), the controller returns to the armed state after each block, and every later trigger starts another block of `num_samples`.
- R6: Trigger events that arrive while `busy` is high start nothing and set the sticky `missed_trig` flag. An `arm` pulse in the idle or armed state clears the flag.
- R7: Trigger events are ignored until an `arm` pulse has been given.
- R8: A `disarm` pulse stops a capture after at most one more sample and returns the controller to idle. `done` does not pulse unless that sample was the last one of the block.
- R9: `done` is high for one cycle, in the same cycle as the last `sample_en` of a block.
- R10: As bus master, a trigger produces a one-cycle `bus_sync_start` on the next tick, then a one-cycle `bus_trig_out` two ticks later. The first sample comes on the tick after `bus_trig_out`.
- R11: With `bus_master` low, `bus_sync_start` and `bus_trig_out` stay low. A rising edge on `bus_trig_in` triggers a slave capture when `src_sel`=3.
- R12: `busy` is high from the trigger until the block ends. After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe per sample-clock period |
| arm | input | 1 | Arm strobe; also clears the missed flag |
| disarm | input | 1 | Disarm strobe |
| src_sel | input | 2 | Trigger source code |
| mode_sel | input | 2 | 0 post, 1 delay, 2 re-trigger, 3 treated as post |
| bus_master | input | 1 | High selects the master role on the shared bus |
| num_samples | input | 16 | Samples per block (0 behaves as 1) |
| delay_ticks | input | 32 | Delay in sample ticks for delay mode |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous external digital trigger |
| ana_trig | input | 1 | Analog comparator event, synchronous |
| bus_trig_in | input | 1 | Asynchronous shared bus trigger line |
| sample_en | output | 1 | One pulse per captured sample |
| busy | output | 1 | Trigger sequence or capture in progress |
| done | output | 1 | End-of-block pulse |
| missed_trig | output | 1 | Sticky flag for ignored triggers |
| bus_sync_start | output | 1 | Sync-start pulse driven in master role |
| bus_trig_out | output | 1 | Shared trigger driven in master role |

## Verification
The hardest case to reach from the ports is a trigger that arrives while a capture is in progress. The test has to show that this trigger starts nothing and leaves only the sticky flag set. To get there, the bench fires a second analog event two ticks into a re-trigger block. It then counts that exactly one block of samples follows, and that a third trigger, given after the block ends, starts the next block. The tick phase is produced by the bench itself and every trigger is aligned to it, so first-sample latencies can be compared exactly between post, delay and master sequences.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_EXT = 2'd1,
    SRC_ANA = 2'd2,
    SRC_BUS = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    MODE_POST   = 2'd0,
    MODE_DELAY  = 2'd1,
    MODE_RETRIG = 2'd2,
    MODE_RSVD   = 2'd3
  } cap_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SYNC_PEND,
    ST_SYNC_GAP,
    ST_DELAY,
    ST_CAPTURE
  } cap_state_e;
endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic level;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign level = din;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= (chain_q << 1) | SYNC_STAGES'(din);
      end
      assign level = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/trig_source_select.sv
module trig_source_select
  import acq_trig_pkg::*;
(
  input  trig_src_e src,
  input  logic      bus_master,
  input  logic      evt_sw,
  input  logic      evt_ext,
  input  logic      evt_ana,
  input  logic      evt_bus,
  output logic      evt_sel
);
  always_comb begin
    unique case (src)
      SRC_SW:  evt_sel = evt_sw;
      SRC_EXT: evt_sel = evt_ext;
      SRC_ANA: evt_sel = evt_ana;
      SRC_BUS: evt_sel = evt_bus & ~bus_master;
      default: evt_sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_capture_fsm.sv
module trig_capture_fsm
  import acq_trig_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm,
  input  logic             disarm,
  input  logic             trig_evt,
  input  cap_mode_e        mode,
  input  logic             bus_master,
  input  logic [CNT_W-1:0] n_samples,
  input  logic [DLY_W-1:0] delay_ticks,
  output logic             sample_en,
  output logic             done,
  output logic             busy,
  output logic             missed,
  output logic             sync_start,
  output logic             bus_trig
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  cap_state_e       state_q, state_d;
  logic [CNT_W-1:0] smp_cnt_q, smp_cnt_d;
  logic [DLY_W-1:0] dly_cnt_q, dly_cnt_d;
  logic             gap_q, gap_d;
  logic             pend_q, pend_d;
  logic             missed_q, missed_d;
  logic             smp_q, smp_d;
  logic             done_q, done_d;
  logic             sync_q, sync_d;
  logic             btrig_q, btrig_d;
  logic             fire;
  logic             in_flight;

  assign in_flight = (state_q == ST_SYNC_PEND) || (state_q == ST_SYNC_GAP) ||
                     (state_q == ST_DELAY)     || (state_q == ST_CAPTURE);

  always_comb begin
    state_d   = state_q;
    smp_cnt_d = smp_cnt_q;
    dly_cnt_d = dly_cnt_q;
    gap_d     = gap_q;
    pend_d    = pend_q;
    missed_d  = missed_q;
    smp_d     = 1'b0;
    done_d    = 1'b0;
    sync_d    = 1'b0;
    btrig_d   = 1'b0;
    fire      = 1'b0;

    if (trig_evt && in_flight) missed_d = 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        if (arm) begin
          state_d  = ST_ARMED;
          missed_d = 1'b0;
        end
      end
      ST_ARMED: begin
        if (arm) missed_d = 1'b0;
        if (disarm) begin
          state_d = ST_IDLE;
        end else if (trig_evt) begin
          if (bus_master) state_d = ST_SYNC_PEND;
          else            fire    = 1'b1;
        end
      end
      ST_SYNC_PEND: begin
        if (disarm) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          sync_d  = 1'b1;
          gap_d   = 1'b0;
          state_d = ST_SYNC_GAP;
        end
      end
      ST_SYNC_GAP: begin
        if (disarm) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          if (gap_q) begin
            btrig_d = 1'b1;
            fire    = 1'b1;
          end else begin
            gap_d = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (disarm) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          if (dly_cnt_q <= DLY_ONE) state_d = ST_CAPTURE;
          else                      dly_cnt_d = dly_cnt_q - DLY_ONE;
        end
      end
      ST_CAPTURE: begin
        if (tick) begin
          smp_d = 1'b1;
          if (smp_cnt_q <= CNT_ONE) begin
            done_d  = 1'b1;
            pend_d  = 1'b0;
            state_d = (mode == MODE_RETRIG && !disarm && !pend_q) ? ST_ARMED : ST_IDLE;
          end else if (disarm || pend_q) begin
            pend_d  = 1'b0;
            state_d = ST_IDLE;
          end else begin
            smp_cnt_d = smp_cnt_q - CNT_ONE;
          end
        end else if (disarm) begin
          pend_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (fire) begin
      smp_cnt_d = n_samples;
      pend_d    = 1'b0;
      if (mode == MODE_DELAY && delay_ticks != '0) begin
        dly_cnt_d = delay_ticks;
        state_d   = ST_DELAY;
      end else begin
        state_d = ST_CAPTURE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      smp_cnt_q <= '0;
      dly_cnt_q <= '0;
      gap_q     <= 1'b0;
      pend_q    <= 1'b0;
      missed_q  <= 1'b0;
      smp_q     <= 1'b0;
      done_q    <= 1'b0;
      sync_q    <= 1'b0;
      btrig_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      smp_cnt_q <= smp_cnt_d;
      dly_cnt_q <= dly_cnt_d;
      gap_q     <= gap_d;
      pend_q    <= pend_d;
      missed_q  <= missed_d;
      smp_q     <= smp_d;
      done_q    <= done_d;
      sync_q    <= sync_d;
      btrig_q   <= btrig_d;
    end
  end

  assign sample_en  = smp_q;
  assign done       = done_q;
  assign busy       = in_flight;
  assign missed     = missed_q;
  assign sync_start = sync_q;
  assign bus_trig   = btrig_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             arm,
  input  logic             disarm,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       mode_sel,
  input  logic             bus_master,
  input  logic [CNT_W-1:0] num_samples,
  input  logic [DLY_W-1:0] delay_ticks,
  input  logic             sw_trig,
  input  logic             ext_trig,
  input  logic             ana_trig,
  input  logic             bus_trig_in,
  output logic             sample_en,
  output logic             busy,
  output logic             done,
  output logic             missed_trig,
  output logic             bus_sync_start,
  output logic             bus_trig_out
);
  localparam int NSRC = 4;

  logic [1:0]      rst_sync_q;
  logic            rst_n_i;
  logic [NSRC-1:0] raw_in;
  logic [NSRC-1:0] rise;
  logic            evt_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign raw_in = {bus_trig_in, ana_trig, ext_trig, sw_trig};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam bit ASYNC_IN = (s == int'(SRC_EXT)) || (s == int'(SRC_BUS));
    trig_edge_detect #(
      .SYNC_STAGES(ASYNC_IN ? SYNC_STAGES : 0)
    ) i_edge (
      .clk  (clk),
      .rst_n(rst_n_i),
      .din  (raw_in[s]),
      .rise (rise[s])
    );
  end

  trig_source_select i_sel (
    .src       (trig_src_e'(src_sel)),
    .bus_master(bus_master),
    .evt_sw    (rise[SRC_SW]),
    .evt_ext   (rise[SRC_EXT]),
    .evt_ana   (rise[SRC_ANA]),
    .evt_bus   (rise[SRC_BUS]),
    .evt_sel   (evt_sel)
  );

  trig_capture_fsm #(
    .CNT_W(CNT_W),
    .DLY_W(DLY_W)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tick       (sample_tick),
    .arm        (arm),
    .disarm     (disarm),
    .trig_evt   (evt_sel),
    .mode       (cap_mode_e'(mode_sel)),
    .bus_master (bus_master),
    .n_samples  (num_samples),
    .delay_ticks(delay_ticks),
    .sample_en  (sample_en),
    .done       (done),
    .busy       (busy),
    .missed     (missed_trig),
    .sync_start (bus_sync_start),
    .bus_trig   (bus_trig_out)
  );
endmodule

// File: rtl/acq_trig_ctrl_sva.sv
module acq_trig_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic sample_tick,
  input logic arm,
  input logic bus_master,
  input logic sample_en,
  input logic busy,
  input logic done,
  input logic missed_trig,
  input logic bus_sync_start,
  input logic bus_trig_out
);
  logic [1:0] since_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_sync_q <= 2'd3;
    end else if (bus_sync_start) begin
      since_sync_q <= sample_tick ? 2'd1 : 2'd0;
    end else if (sample_tick && since_sync_q != 2'd3) begin
      since_sync_q <= since_sync_q + 2'd1;
    end
  end

  AST_DONE_ON_LAST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sample_en); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sync_start |=> !bus_sync_start); // R10
  AST_BUS_TRIG_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trig_out |-> since_sync_q == 2'd2); // R10
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_master && $stable(bus_master)) |=> !bus_sync_start || $past(bus_master)); // R11
  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> $past(busy)); // R12
  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_trig && !arm) |=> missed_trig); // R6
endmodule

bind acq_trig_ctrl acq_trig_ctrl_sva i_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_tick   (sample_tick),
  .arm           (arm),
  .bus_master    (bus_master),
  .sample_en     (sample_en),
  .busy          (busy),
  .done          (done),
  .missed_trig   (missed_trig),
  .bus_sync_start(bus_sync_start),
  .bus_trig_out  (bus_trig_out)
);

// File: tb/test_acq_trig_ctrl.sv
`timescale 1ns/1ps
module test_acq_trig_ctrl;
  logic        clk;
  logic        rst_n;
  logic        sample_tick;
  logic        arm, disarm;
  logic [1:0]  src_sel, mode_sel;
  logic        bus_master;
  logic [15:0] num_samples;
  logic [31:0] delay_ticks;
  logic        sw_trig, ext_trig, ana_trig, bus_trig_in;
  logic        sample_en, busy, done, missed_trig, bus_sync_start, bus_trig_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tick_no = 0;
  int phase = 0;
  int smp_cnt = 0;
  int smp_ticks[256];
  int done_cnt = 0;
  int done_tick = -1;
  int sync_cnt = 0;
  int sync_tick = -1;
  int btrig_cnt = 0;
  int btrig_tick = -1;
  int trig_tick = 0;
  bit finished = 0;

  acq_trig_ctrl i_acq_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .arm(arm), .disarm(disarm),
    .src_sel(src_sel), .mode_sel(mode_sel), .bus_master(bus_master),
    .num_samples(num_samples), .delay_ticks(delay_ticks),
    .sw_trig(sw_trig), .ext_trig(ext_trig), .ana_trig(ana_trig), .bus_trig_in(bus_trig_in),
    .sample_en(sample_en), .busy(busy), .done(done), .missed_trig(missed_trig),
    .bus_sync_start(bus_sync_start), .bus_trig_out(bus_trig_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor and tick generator: one tick every fourth cycle.
  initial sample_tick = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sample_tick) tick_no++;
    if (sample_en) begin
      smp_ticks[smp_cnt % 256] = tick_no;
      smp_cnt++;
    end
    if (done) begin
      done_cnt++;
      done_tick = tick_no;
    end
    if (bus_sync_start) begin
      sync_cnt++;
      sync_tick = tick_no;
    end
    if (bus_trig_out) begin
      btrig_cnt++;
      btrig_tick = tick_no;
    end
    phase = (phase + 1) % 4;
    sample_tick = (phase == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic align();
    step(1);
    while (phase != 0) step(1);
  endtask

  task automatic strobe_arm();
    arm = 1'b1; step(1); arm = 1'b0;
  endtask

  task automatic strobe_disarm();
    disarm = 1'b1; step(1); disarm = 1'b0;
  endtask

  // which: 0 sw, 2 analog (one-cycle strobes)
  task automatic strobe_src(input int which);
    align();
    trig_tick = tick_no;
    if (which == 0) sw_trig = 1'b1; else ana_trig = 1'b1;
    step(1);
    sw_trig = 1'b0;
    ana_trig = 1'b0;
  endtask

  task automatic cfg(input int src, input int mode, input bit master, input int n, input int d);
    src_sel = 2'(src);
    mode_sel = 2'(mode);
    bus_master = master;
    num_samples = 16'(n);
    delay_ticks = 32'(d);
    step(2);
  endtask

  task automatic t_reset();
    chk(sample_en == 0 && done == 0, "R12 reset sample/done", int'(sample_en), 0);
    chk(busy == 0 && missed_trig == 0, "R12 reset busy/missed", int'(busy), 0);
    chk(bus_sync_start == 0 && bus_trig_out == 0, "R11 reset bus outputs", int'(bus_trig_out), 0);
  endtask

  task automatic t_unarmed();
    int s0;
    cfg(0, 0, 0, 3, 0);
    s0 = smp_cnt;
    strobe_src(0);
    step(40);
    chk(smp_cnt == s0, "R7 trigger while unarmed", smp_cnt - s0, 0);
    chk(busy == 0, "R7 busy while unarmed", int'(busy), 0);
  endtask

  task automatic t_post();
    int s0, d0, s1;
    cfg(0, 0, 0, 5, 9);
    strobe_arm();
    s0 = smp_cnt; d0 = done_cnt;
    strobe_src(0);
    step(2);
    chk(busy == 1, "R12 busy during block", int'(busy), 1);
    step(40);
    chk(smp_cnt - s0 == 5, "R3 post sample count", smp_cnt - s0, 5);
    chk(smp_ticks[s0 % 256] - trig_tick == 1, "R3 post first-sample latency",
        smp_ticks[s0 % 256] - trig_tick, 1);
    chk(done_cnt - d0 == 1, "R9 one done per block", done_cnt - d0, 1);
    chk(done_tick == smp_ticks[(s0 + 4) % 256], "R9 done with last sample",
        done_tick, smp_ticks[(s0 + 4) % 256]);
    chk(busy == 0, "R12 busy after block", int'(busy), 0);
    s1 = smp_cnt;
    strobe_src(0);
    step(40);
    chk(smp_cnt == s1, "R3 idle after post block", smp_cnt - s1, 0);
  endtask

  task automatic t_delay();
    int s0;
    cfg(0, 1, 0, 2, 7);
    strobe_arm();
    s0 = smp_cnt;
    strobe_src(0);
    step(80);
    chk(smp_cnt - s0 == 2, "R4 delay sample count", smp_cnt - s0, 2);
    chk(smp_ticks[s0 % 256] - trig_tick == 8, "R4 delay latency",
        smp_ticks[s0 % 256] - trig_tick, 8);
    cfg(0, 1, 0, 2, 0);
    strobe_arm();
    s0 = smp_cnt;
    strobe_src(0);
    step(40);
    chk(smp_ticks[s0 % 256] - trig_tick == 1, "R4 zero delay equals post",
        smp_ticks[s0 % 256] - trig_tick, 1);
  endtask

  task automatic t_retrig();
    int s0;
    cfg(2, 2, 0, 4, 0);
    strobe_arm();
    s0 = smp_cnt;
    strobe_src(2);
    step(8);
    strobe_src(2);
    step(40);
    chk(smp_cnt - s0 == 4, "R6 trigger during block ignored", smp_cnt - s0, 4);
    chk(missed_trig == 1, "R6 missed flag set", int'(missed_trig), 1);
    strobe_src(2);
    step(40);
    chk(smp_cnt - s0 == 8, "R5 second block after retrigger", smp_cnt - s0, 8);
    chk(busy == 0, "R5 back to armed", int'(busy), 0);
    chk(missed_trig == 1, "R6 missed flag sticky", int'(missed_trig), 1);
    strobe_arm();
    step(1);
    chk(missed_trig == 0, "R6 arm clears missed", int'(missed_trig), 0);
    strobe_disarm();
    s0 = smp_cnt;
    strobe_src(2);
    step(40);
    chk(smp_cnt == s0, "R5 disarm stops retrigger", smp_cnt - s0, 0);
  endtask

  task automatic t_ext_level();
    int s0;
    cfg(1, 2, 0, 3, 0);
    strobe_arm();
    s0 = smp_cnt;
    strobe_src(0);
    step(40);
    chk(smp_cnt == s0, "R1 unselected source ignored", smp_cnt - s0, 0);
    ext_trig = 1'b1;
    step(60);
    chk(smp_cnt - s0 == 3, "R2 held level gives one block", smp_cnt - s0, 3);
    ext_trig = 1'b0;
    step(5);
    ext_trig = 1'b1;
    step(40);
    ext_trig = 1'b0;
    chk(smp_cnt - s0 == 6, "R2 new rising edge retriggers", smp_cnt - s0, 6);
    strobe_disarm();
    step(4);
  endtask

  task automatic t_master();
    int s0, y0, b0;
    cfg(0, 0, 1, 2, 0);
    strobe_arm();
    s0 = smp_cnt; y0 = sync_cnt; b0 = btrig_cnt;
    strobe_src(0);
    step(60);
    chk(sync_cnt - y0 == 1, "R10 one sync-start cycle", sync_cnt - y0, 1);
    chk(btrig_cnt - b0 == 1, "R10 one bus trigger cycle", btrig_cnt - b0, 1);
    chk(sync_tick - trig_tick == 1, "R10 sync on next tick", sync_tick - trig_tick, 1);
    chk(btrig_tick - sync_tick == 2, "R10 bus trigger two ticks later", btrig_tick - sync_tick, 2);
    chk(smp_ticks[s0 % 256] - btrig_tick == 1, "R10 sample after bus trigger",
        smp_ticks[s0 % 256] - btrig_tick, 1);
    chk(smp_cnt - s0 == 2, "R10 master sample count", smp_cnt - s0, 2);
  endtask

  task automatic t_slave();
    int s0, y0, b0;
    cfg(3, 0, 0, 3, 0);
    strobe_arm();
    s0 = smp_cnt; y0 = sync_cnt; b0 = btrig_cnt;
    bus_trig_in = 1'b1;
    step(50);
    bus_trig_in = 1'b0;
    chk(smp_cnt - s0 == 3, "R11 slave capture on bus line", smp_cnt - s0, 3);
    chk(sync_cnt == y0 && btrig_cnt == b0, "R11 slave drives nothing",
        (sync_cnt - y0) + (btrig_cnt - b0), 0);
    cfg(3, 0, 1, 3, 0);
    strobe_arm();
    s0 = smp_cnt;
    bus_trig_in = 1'b1;
    step(50);
    bus_trig_in = 1'b0;
    chk(smp_cnt == s0, "R1 bus source void in master role", smp_cnt - s0, 0);
    strobe_disarm();
  endtask

  task automatic t_disarm();
    int s0, a, d0;
    cfg(0, 0, 0, 20, 0);
    strobe_arm();
    s0 = smp_cnt; d0 = done_cnt;
    strobe_src(0);
    step(21);
    a = smp_cnt;
    strobe_disarm();
    step(40);
    chk(smp_cnt - a <= 1, "R8 at most one sample after disarm", smp_cnt - a, 1);
    chk(smp_cnt - s0 < 20, "R8 block cut short", smp_cnt - s0, 19);
    chk(done_cnt == d0, "R8 no done on disarm", done_cnt - d0, 0);
    chk(busy == 0, "R8 idle after disarm", int'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    arm = 0; disarm = 0; src_sel = 0; mode_sel = 0; bus_master = 0;
    num_samples = 16'd1; delay_ticks = 32'd0;
    sw_trig = 0; ext_trig = 0; ana_trig = 0; bus_trig_in = 0;
    step(5);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_unarmed();
    t_post();
    t_delay();
    t_retrig();
    t_ext_level();
    t_master();
    t_slave();
    t_disarm();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule